// File: doc/BRIEF.md
# Complementary PWM Deadtime Inserter

This block turns one raw PWM reference into a pair of complementary switch drives, a high-side output and a low-side output. Each time the reference changes level, the output that must turn off does so at once. The output that must turn on waits for a programmed dead interval, so the two switches are never driven together. The interval is set as a count of prescaled PWM clock periods and converted to bus clock cycles using the current prescaler ratio.

The dead interval setting sits in a register that can be read back. A sticky lock bit, once set, freezes it until reset. A generator enable gates the pair. It can only be written while an external master-permit input is high, and it clears whenever that permit is low. A per-output override forces a chosen level onto either output, whether the generator is enabled or not.

Top module: `cpwm_deadband`

## Requirements
- R1: After reset the deadtime setting reads 0x0FFF, the lock and the generator enable read 0, and both outputs are 0.
- R2: `dt_rdata` returns the 12-bit setting in bits 11:0 with bits 15:12 zero, and the upper 4 bits of a write are discarded.
- R3: The dead interval in bus cycles is D = S when the prescaler ratio P is 1 or 0 (0 is treated as 1), D = P*S-1 when P >= 2 and S > 0, and D = 0 when S = 0.
- R4: On the first clock edge that sees the reference changed, the output of the old level goes to 0. The output of the new level (`out_hi` for 1, `out_lo` for 0) goes to 1 exactly D clock edges later, giving D cycles with both outputs 0.
- R5: If the reference changes again before its dead interval ends, the pending output never turns on for that pulse and a fresh interval starts toward the new level.
- R6: With no override active, `out_hi` and `out_lo` are never 1 in the same cycle.
- R7: A pulse on `lock_set` sets the lock one cycle later. The lock stays set until reset, and while it is set, writes to the setting leave `dt_rdata` unchanged.
- R8: A write to the generator enable takes effect only while `master_ok` is 1. While `master_ok` is 0, the enable clears on the next edge and reads 0.
- R9: While the generator is disabled, each output without an override reads 0.
- R10: An output whose bit in `ovr_en` is set (bit 1 = `out_hi`, bit 0 = `out_lo`) shows the matching bit of `ovr_lvl` in the same cycle, regardless of the enable.
- R11: The prescaler ratio and the setting are sampled only at a reference edge. Changing either during a running interval does not alter that interval's length, and the new values apply from the next edge.
- R12: After the generator is enabled, the block starts as if the reference had just changed to its present level: both outputs stay 0 for D cycles, then the matching output turns on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_ref | input | 1 | Raw PWM reference |
| presc_ratio | input | 4 | PWM clock divide ratio P |
| dt_wr | input | 1 | Write strobe for the deadtime setting |
| dt_wdata | input | 16 | Write data for the setting (bits 11:0 used) |
| dt_rdata | output | 16 | Setting readback |
| lock_set | input | 1 | Sets the configuration lock |
| lock_o | output | 1 | Lock state |
| master_ok | input | 1 | Permit for the generator enable |
| en_wr | input | 1 | Write strobe for the generator enable |
| en_wdata | input | 1 | Value written to the generator enable |
| en_rd | output | 1 | Generator enable readback |
| ovr_en | input | 2 | Override select, bit 1 high side, bit 0 low side |
| ovr_lvl | input | 2 | Override levels, same bit order |
| out_hi | output | 1 | High-side drive |
| out_lo | output | 1 | Low-side drive |

## Verification
Writes to the setting, the lock and the enable become visible one clock edge after the strobe. Overrides act on the outputs in the same cycle, with no register in the path. After a reference change, the turn-off is due on the first edge that samples it and the turn-on D edges after that. The bench therefore drives inputs just after a rising edge and compares a behavioural model on every falling edge. It measures each dead interval as the number of sampled cycles with both outputs low before the target output rises, and compares that count with the D formula.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
    localparam int unsigned DT_W_DEF = 12;
    localparam int unsigned PS_W_DEF = 4;
    localparam int unsigned REG_W    = 16;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DEAD = 2'd1,
        PH_ON   = 2'd2
    } phase_e;
endpackage

// File: rtl/cpwm_dur_calc.sv
module cpwm_dur_calc #(
    parameter int unsigned DT_W = cpwm_pkg::DT_W_DEF,
    parameter int unsigned PS_W = cpwm_pkg::PS_W_DEF,
    localparam int unsigned DUR_W = DT_W + PS_W
) (
    input  logic [PS_W-1:0]  ratio,
    input  logic [DT_W-1:0]  setting,
    output logic [DUR_W-1:0] dur
);
    logic [DUR_W-1:0] prod;

    always_comb begin
        prod = DUR_W'(ratio) * DUR_W'(setting);
        if (ratio <= PS_W'(1)) begin
            dur = DUR_W'(setting);
        end else if (setting == '0) begin
            dur = '0;
        end else begin
            dur = prod - DUR_W'(1);
        end
    end
endmodule

// File: rtl/cpwm_cfg_regs.sv
module cpwm_cfg_regs #(
    parameter int unsigned DT_W = cpwm_pkg::DT_W_DEF,
    localparam int unsigned RW = cpwm_pkg::REG_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dt_wr,
    input  logic [RW-1:0]   dt_wdata,
    input  logic            lock_set,
    input  logic            master_ok,
    input  logic            en_wr,
    input  logic            en_wdata,
    output logic [DT_W-1:0] setting,
    output logic            locked,
    output logic            gen_en
);
    typedef struct packed {
        logic [DT_W-1:0] dt;
        logic            lock;
        logic            en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        cfg_d.lock = cfg_q.lock | lock_set;
        if (dt_wr && !cfg_q.lock) begin
            cfg_d.dt = dt_wdata[DT_W-1:0];
        end
        if (!master_ok) begin
            cfg_d.en = 1'b0;
        end else if (en_wr) begin
            cfg_d.en = en_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.dt   <= '1;
            cfg_q.lock <= 1'b0;
            cfg_q.en   <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign setting = cfg_q.dt;
    assign locked  = cfg_q.lock;
    assign gen_en  = cfg_q.en;
endmodule

// File: rtl/cpwm_edge_core.sv
module cpwm_edge_core #(
    parameter int unsigned DUR_W = cpwm_pkg::DT_W_DEF + cpwm_pkg::PS_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             ref_in,
    input  logic [DUR_W-1:0] dur,
    output logic             drv_hi,
    output logic             drv_lo
);
    import cpwm_pkg::*;

    typedef struct packed {
        phase_e           ph;
        logic             tgt;
        logic [DUR_W-1:0] cnt;
    } core_t;

    core_t st_d, st_q;
    logic  start;

    always_comb begin
        st_d  = st_q;
        start = (st_q.ph == PH_IDLE) || (ref_in != st_q.tgt);
        if (!enable) begin
            st_d.ph  = PH_IDLE;
            st_d.tgt = 1'b0;
            st_d.cnt = '0;
        end else if (start) begin
            st_d.tgt = ref_in;
            st_d.cnt = dur;
            st_d.ph  = (dur == '0) ? PH_ON : PH_DEAD;
        end else if (st_q.ph == PH_DEAD) begin
            st_d.cnt = st_q.cnt - DUR_W'(1);
            if (st_q.cnt == DUR_W'(1)) begin
                st_d.ph = PH_ON;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ph  <= PH_IDLE;
            st_q.tgt <= 1'b0;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign drv_hi = (st_q.ph == PH_ON) &&  st_q.tgt;
    assign drv_lo = (st_q.ph == PH_ON) && !st_q.tgt;
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
    parameter int unsigned DT_W = cpwm_pkg::DT_W_DEF,
    parameter int unsigned PS_W = cpwm_pkg::PS_W_DEF,
    localparam int unsigned RW    = cpwm_pkg::REG_W,
    localparam int unsigned DUR_W = DT_W + PS_W,
    localparam int unsigned NOUT  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwm_ref,
    input  logic [PS_W-1:0] presc_ratio,
    input  logic            dt_wr,
    input  logic [RW-1:0]   dt_wdata,
    output logic [RW-1:0]   dt_rdata,
    input  logic            lock_set,
    output logic            lock_o,
    input  logic            master_ok,
    input  logic            en_wr,
    input  logic            en_wdata,
    output logic            en_rd,
    input  logic [NOUT-1:0] ovr_en,
    input  logic [NOUT-1:0] ovr_lvl,
    output logic            out_hi,
    output logic            out_lo
);
    logic [DT_W-1:0]  setting;
    logic             gen_en;
    logic [DUR_W-1:0] dur;
    logic             drv_hi, drv_lo;
    logic [NOUT-1:0]  raw, outs;

    cpwm_cfg_regs #(.DT_W(DT_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .dt_wr    (dt_wr),
        .dt_wdata (dt_wdata),
        .lock_set (lock_set),
        .master_ok(master_ok),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .setting  (setting),
        .locked   (lock_o),
        .gen_en   (gen_en)
    );

    cpwm_dur_calc #(.DT_W(DT_W), .PS_W(PS_W)) u_dur (
        .ratio  (presc_ratio),
        .setting(setting),
        .dur    (dur)
    );

    cpwm_edge_core #(.DUR_W(DUR_W)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(gen_en),
        .ref_in(pwm_ref),
        .dur   (dur),
        .drv_hi(drv_hi),
        .drv_lo(drv_lo)
    );

    assign raw = {drv_hi, drv_lo};

    for (genvar i = 0; i < NOUT; i++) begin : g_out
        assign outs[i] = ovr_en[i] ? ovr_lvl[i] : (gen_en & raw[i]);
    end

    assign out_hi   = outs[1];
    assign out_lo   = outs[0];
    assign en_rd    = gen_en;
    assign dt_rdata = {{(RW-DT_W){1'b0}}, setting};
endmodule

// File: rtl/cpwm_deadband_chk.sv
module cpwm_deadband_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] dt_rdata,
    input logic        lock_o,
    input logic        master_ok,
    input logic        en_rd,
    input logic [1:0]  ovr_en,
    input logic [1:0]  ovr_lvl,
    input logic        out_hi,
    input logic        out_lo
);
    // R6
    pair_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_en == 2'b00) |-> !(out_hi && out_lo));

    // R7
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |=> lock_o);

    // R7
    locked_setting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |=> $stable(dt_rdata));

    // R8
    permit_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_ok |=> !en_rd);

    // R9
    disabled_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_rd && !ovr_en[1]) |-> !out_hi);

    // R9
    disabled_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_rd && !ovr_en[0]) |-> !out_lo);

    // R10
    override_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_en[1] |-> (out_hi == ovr_lvl[1]));
endmodule

bind cpwm_deadband cpwm_deadband_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dt_rdata (dt_rdata),
    .lock_o   (lock_o),
    .master_ok(master_ok),
    .en_rd    (en_rd),
    .ovr_en   (ovr_en),
    .ovr_lvl  (ovr_lvl),
    .out_hi   (out_hi),
    .out_lo   (out_lo)
);

// File: tb/sim_cpwm_deadband.sv
`timescale 1ns/1ps
module sim_cpwm_deadband;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwm_ref = 1'b0;
    logic [3:0]  presc_ratio = 4'd1;
    logic        dt_wr = 1'b0;
    logic [15:0] dt_wdata = '0;
    logic [15:0] dt_rdata;
    logic        lock_set = 1'b0;
    logic        lock_o;
    logic        master_ok = 1'b0;
    logic        en_wr = 1'b0;
    logic        en_wdata = 1'b0;
    logic        en_rd;
    logic [1:0]  ovr_en = 2'b00;
    logic [1:0]  ovr_lvl = 2'b00;
    logic        out_hi, out_lo;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    cpwm_deadband u0 (.*);

    // behavioural reference model
    int m_dt, m_lock, m_en, m_phase, m_tgt, m_cnt;

    function automatic int dur_of(int p, int s);
        if (p <= 1) return s;
        if (s == 0) return 0;
        return p * s - 1;
    endfunction

    always @(posedge clk) begin
        int old_dt, old_en;
        if (!rst_n) begin
            m_dt = 4095; m_lock = 0; m_en = 0; m_phase = 0; m_tgt = 0; m_cnt = 0;
        end else begin
            old_dt = m_dt; old_en = m_en;
            if (dt_wr && m_lock == 0) m_dt = dt_wdata & 16'h0FFF;
            if (lock_set) m_lock = 1;
            if (!master_ok) m_en = 0;
            else if (en_wr) m_en = en_wdata;
            if (old_en == 0) begin
                m_phase = 0; m_tgt = 0; m_cnt = 0;
            end else if (m_phase == 0 || int'(pwm_ref) != m_tgt) begin
                m_tgt = pwm_ref;
                m_cnt = dur_of(presc_ratio, old_dt);
                m_phase = (m_cnt == 0) ? 2 : 1;
            end else if (m_phase == 1) begin
                m_cnt--;
                if (m_cnt == 0) m_phase = 2;
            end
        end
    end

    function automatic logic exp_out(int idx);
        logic raw;
        if (ovr_en[idx]) return ovr_lvl[idx];
        raw = (m_phase == 2) && (m_tgt == idx);
        return (m_en != 0) && raw;
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // per-cycle comparison against the model (R4, R6, R1/R2 readback)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(out_hi == exp_out(1), "R4 model out_hi", out_hi, exp_out(1));
            check(out_lo == exp_out(0), "R4 model out_lo", out_lo, exp_out(0));
            check(dt_rdata == 16'(m_dt), "R2 model readback", dt_rdata, m_dt);
            check(en_rd == (m_en != 0), "R8 model enable", en_rd, m_en);
            check(lock_o == (m_lock != 0), "R7 model lock", lock_o, m_lock);
            if (ovr_en == 2'b00)
                check(!(out_hi && out_lo), "R6 pair exclusive", {out_hi, out_lo}, 0);
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic write_dt(logic [15:0] v);
        dt_wr = 1'b1; dt_wdata = v;
        tick();
        dt_wr = 1'b0;
    endtask

    task automatic meas(logic lvl, int expv, string tag);
        int cnt = 0;
        pwm_ref = lvl;
        for (int i = 0; i < 70000; i++) begin
            tick();
            if ((lvl ? out_hi : out_lo) == 1'b1) break;
            if (!out_hi && !out_lo) cnt++;
        end
        check(cnt == expv, tag, cnt, expv);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int cnt;
        bit seen;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1
        check(dt_rdata == 16'h0FFF, "R1 reset setting", dt_rdata, 16'h0FFF);
        check(!lock_o && !en_rd, "R1 reset lock/en", {lock_o, en_rd}, 0);
        check(!out_hi && !out_lo, "R1 reset outputs", {out_hi, out_lo}, 0);

        // R2: upper nibble dropped
        write_dt(16'hF005);
        check(dt_rdata == 16'h0005, "R2 masked write", dt_rdata, 5);

        // R12: enable with P=2, S=5 -> low side after 9
        presc_ratio = 4'd2;
        master_ok = 1'b1; en_wr = 1'b1; en_wdata = 1'b1;
        tick();
        en_wr = 1'b0;
        check(en_rd == 1'b1, "R8 enable write", en_rd, 1);
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (out_lo) break;
            cnt++;
        end
        check(cnt == 9, "R12 start interval", cnt, 9);

        // R3/R4 gap lengths
        meas(1'b1, 9, "R3 P2 S5 rise");
        meas(1'b0, 9, "R4 P2 S5 fall");
        presc_ratio = 4'd1; write_dt(16'd3);
        meas(1'b1, 3, "R3 P1 S3 rise");
        presc_ratio = 4'd3; write_dt(16'd4);
        meas(1'b0, 11, "R3 P3 S4 fall");
        presc_ratio = 4'd0; write_dt(16'd3);
        meas(1'b1, 3, "R3 P0 as P1");
        presc_ratio = 4'd2; write_dt(16'd0);
        meas(1'b0, 0, "R3 S0 P2");

        // R5: short pulse
        presc_ratio = 4'd1; write_dt(16'd6);
        repeat (3) tick();
        pwm_ref = 1'b1;
        repeat (3) tick();
        pwm_ref = 1'b0;
        seen = 0;
        for (int i = 0; i < 10; i++) begin
            tick();
            if (out_hi) seen = 1;
        end
        check(!seen, "R5 short pulse high side", seen, 0);
        check(out_lo == 1'b1, "R5 low side back", out_lo, 1);

        // R11: mid-interval change
        write_dt(16'd8);
        pwm_ref = 1'b1;
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            if (i == 2) begin
                dt_wr = 1'b1; dt_wdata = 16'd2; presc_ratio = 4'd3;
            end
            if (i == 3) dt_wr = 1'b0;
            tick();
            if (out_hi) break;
            if (!out_lo) cnt++;
        end
        dt_wr = 1'b0;
        check(cnt == 8, "R11 running interval kept", cnt, 8);
        meas(1'b0, 5, "R11 new values next edge");

        // R7: lock
        lock_set = 1'b1; tick(); lock_set = 1'b0;
        check(lock_o == 1'b1, "R7 lock set", lock_o, 1);
        write_dt(16'h0ABC);
        check(dt_rdata == 16'h0002, "R7 locked write ignored", dt_rdata, 2);
        repeat (4) tick();
        check(lock_o == 1'b1, "R7 lock sticky", lock_o, 1);

        // R10: override while enabled, same cycle
        ovr_en = 2'b11; ovr_lvl = 2'b10;
        #1;
        check(out_hi == 1'b1 && out_lo == 1'b0, "R10 override enabled", {out_hi, out_lo}, 2);
        tick();
        ovr_en = 2'b00;

        // R8/R9: permit removed
        master_ok = 1'b0;
        tick();
        check(en_rd == 1'b0, "R8 permit clears", en_rd, 0);
        check(!out_hi && !out_lo, "R9 disabled outputs", {out_hi, out_lo}, 0);
        en_wr = 1'b1; en_wdata = 1'b1; tick(); en_wr = 1'b0;
        check(en_rd == 1'b0, "R8 write blocked", en_rd, 0);
        pwm_ref = 1'b1;
        repeat (5) tick();
        check(!out_hi && !out_lo, "R9 ref ignored while disabled", {out_hi, out_lo}, 0);
        ovr_en = 2'b01; ovr_lvl = 2'b01;
        #1;
        check(out_lo == 1'b1 && out_hi == 1'b0, "R10 override disabled", {out_hi, out_lo}, 1);
        tick();
        ovr_en = 2'b00;
        tick();

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule